// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block forms the second operand of a 32-bit RISC data path. It takes a source word and moves it left, right (logically or arithmetically) or rotates it right. The distance comes from a 5-bit field held in the instruction, or from the low byte of a register. Beside the moved word it delivers the carry bit that the shifter hands to the flag logic. A distance of zero does not simply mean "no move". Its meaning depends on the kind of shift and on where the distance came from.

A second path builds rotated constants. It takes an 8-bit constant from bits 7:0 of the source word and rotates it right by twice the 4-bit field in bits 11:8. A select input picks this path instead of the shift path.

The block is purely combinational, with no clock, reset or state. The ALU and the flag register sit outside it.

Top module: `opshift_unit`

## Requirements
- R1: `shift_kind` encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. For a distance n in 1..31, `result` is the source moved by n the chosen way.
- R2: For a distance n in 1..31, `carry_out` depends on the kind:
  - logical left gives source bit (32-n);
  - the three right kinds give source bit (n-1).
- R3: A zero distance returns the source unchanged with `carry_out` = `carry_in` in these cases:
  - logical left and arithmetic right, from either source;
  - logical right and rotate right when the distance is register-sourced (`amt_is_reg`=1).
- R4: Logical right with a zero immediate distance gives `result` = 0 and `carry_out` = source bit 31.
- R5: Rotate right with a zero immediate distance rotates one bit through the carry: `result` = {`carry_in`, source[31:1]} and `carry_out` = source bit 0.
- R6: Arithmetic right by a register distance of 32 or more fills every result bit with source bit 31, and `carry_out` equals source bit 31.
- R7: Logical shifts by a register distance of 32 or more give `result` = 0. The carry depends on the distance:
  - at exactly 32 it is source bit 0 for left and source bit 31 for right;
  - above 32 it is 0.
- R8: Rotate right by a register distance n of 32 or more rotates by n mod 32. `carry_out` is source bit ((n-1) mod 32), so a distance of 32 returns the source unchanged with carry = bit 31.
- R9: With `amt_is_reg`=0 only `shift_amt[4:0]` is used, and bits 7:5 have no effect on either output.
- R10: With `imm_sel`=1, `result` is the zero-extended `op_in[7:0]` rotated right by 2×`op_in[11:8]`. In this mode `shift_kind`, `shift_amt` and `amt_is_reg` have no effect. `carry_out` is `carry_in` when `op_in[11:8]` is 0, and otherwise the result's bit 31.
- R11: Both outputs follow any input change without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_in | input | 32 | Source word; bits 11:0 also carry the rotated-constant fields |
| shift_kind | input | 2 | Kind of shift (R1 encoding) |
| shift_amt | input | 8 | Shift distance; only bits 4:0 are used when immediate |
| amt_is_reg | input | 1 | 1 = distance came from a register |
| carry_in | input | 1 | Current carry flag |
| imm_sel | input | 1 | 1 = rotated 8-bit constant path |
| result | output | 32 | Shifted or rotated word |
| carry_out | output | 1 | Shifter carry |

## Verification
The checker evaluates its properties whenever the combinational outputs settle. It takes for granted that every input is a known 0/1 value, and that inputs change no more than once per evaluation. The stimulus meets both assumptions: it drives all inputs at a single point in each cycle from 2-state values and samples half a cycle later. Random distances cover the full 8-bit range, and directed vectors bias toward 0, 1, 31, 32, 33 and 255, which are where the zero-distance and large-distance rules take over.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

    typedef enum logic [1:0] {
        KIND_LSL = 2'd0,
        KIND_LSR = 2'd1,
        KIND_ASR = 2'd2,
        KIND_ROR = 2'd3
    } shift_kind_e;

    // Classification of an effective shift distance
    typedef struct packed {
        logic is_zero;   // distance == 0
        logic is_big;    // distance >= data width
        logic is_exact;  // distance == data width
    } amt_class_t;

endpackage

// File: rtl/opshift_amount.sv
module opshift_amount
    import opshift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    localparam int SHW      = $clog2(DATA_W)
) (
    input  logic [REG_AMT_W-1:0] amt_raw,
    input  logic                 from_reg,
    output logic [REG_AMT_W-1:0] amt_eff,
    output logic [SHW-1:0]       amt_low,
    output amt_class_t           amt_cls
);

    always_comb begin
        // Immediate distances only carry SHW meaningful bits
        if (from_reg) amt_eff = amt_raw;
        else          amt_eff = {{(REG_AMT_W-SHW){1'b0}}, amt_raw[SHW-1:0]};
        amt_low          = amt_eff[SHW-1:0];
        amt_cls.is_zero  = (amt_eff == '0);
        amt_cls.is_big   = (amt_eff >= REG_AMT_W'(DATA_W));
        amt_cls.is_exact = (amt_eff == REG_AMT_W'(DATA_W));
    end

endmodule

// File: rtl/opshift_rotator.sv
module opshift_rotator #(
    parameter int W  = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   dout
);

    logic [W-1:0] stage [SHW+1];

    assign stage[0] = din;

    // Log-depth right rotator: stage g rotates by 2**g when amt[g] is set
    for (genvar g = 0; g < SHW; g++) begin : g_stage
        localparam int S = 1 << g;
        assign stage[g+1] = amt[g] ? {stage[g][S-1:0], stage[g][W-1:S]} : stage[g];
    end

    assign dout = stage[SHW];

endmodule

// File: rtl/opshift_core.sv
module opshift_core
    import opshift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    localparam int SHW      = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]    src,
    input  shift_kind_e          kind,
    input  logic [REG_AMT_W-1:0] amt_raw,
    input  logic                 from_reg,
    input  logic                 cin,
    output logic [DATA_W-1:0]    res,
    output logic                 cout
);

    logic [REG_AMT_W-1:0] amt_eff;
    logic [SHW-1:0]       low;
    amt_class_t           cls;
    logic [DATA_W-1:0]    rot;
    logic [SHW-1:0]       left_idx;
    logic [SHW-1:0]       right_idx;
    logic                 sign;

    opshift_amount #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) u_amt (
        .amt_raw  (amt_raw),
        .from_reg (from_reg),
        .amt_eff  (amt_eff),
        .amt_low  (low),
        .amt_cls  (cls)
    );

    opshift_rotator #(.W(DATA_W)) u_rot (
        .din  (src),
        .amt  (low),
        .dout (rot)
    );

    // Carry taps: (W - n) mod W for left, (n - 1) mod W for right kinds
    assign left_idx  = SHW'(0) - low;
    assign right_idx = low - SHW'(1);
    assign sign      = src[DATA_W-1];

    always_comb begin
        res  = src;
        cout = cin;
        unique case (kind)
            KIND_LSL: begin
                if (cls.is_zero) begin
                    res  = src;
                    cout = cin;
                end else if (!cls.is_big) begin
                    res  = src << low;
                    cout = src[left_idx];
                end else begin
                    res  = '0;
                    cout = cls.is_exact & src[0];
                end
            end
            KIND_LSR: begin
                if (cls.is_zero) begin
                    // register zero: pass; immediate zero means a full-width shift
                    res  = from_reg ? src : '0;
                    cout = from_reg ? cin : sign;
                end else if (!cls.is_big) begin
                    res  = src >> low;
                    cout = src[right_idx];
                end else begin
                    res  = '0;
                    cout = cls.is_exact & sign;
                end
            end
            KIND_ASR: begin
                if (cls.is_zero) begin
                    res  = src;
                    cout = cin;
                end else if (!cls.is_big) begin
                    res  = DATA_W'($signed(src) >>> low);
                    cout = src[right_idx];
                end else begin
                    res  = {DATA_W{sign}};
                    cout = sign;
                end
            end
            KIND_ROR: begin
                if (cls.is_zero) begin
                    if (from_reg) begin
                        res  = src;
                        cout = cin;
                    end else begin
                        // one-bit rotate through the carry
                        res  = {cin, src[DATA_W-1:1]};
                        cout = src[0];
                    end
                end else begin
                    res  = rot;
                    cout = src[right_idx];
                end
            end
            default: begin
                res  = src;
                cout = cin;
            end
        endcase
    end

endmodule

// File: rtl/opshift_unit.sv
module opshift_unit
    import opshift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    parameter int CONST_W   = 8,
    parameter int ROTF_W    = 4
) (
    input  logic [DATA_W-1:0]    op_in,
    input  logic [1:0]           shift_kind,
    input  logic [REG_AMT_W-1:0] shift_amt,
    input  logic                 amt_is_reg,
    input  logic                 carry_in,
    input  logic                 imm_sel,
    output logic [DATA_W-1:0]    result,
    output logic                 carry_out
);

    localparam int SHW = $clog2(DATA_W);

    logic [DATA_W-1:0] sh_res;
    logic              sh_cout;
    logic [DATA_W-1:0] k_src;
    logic [ROTF_W-1:0] k_field;
    logic [SHW-1:0]    k_amt;
    logic [DATA_W-1:0] k_res;

    opshift_core #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) u_core (
        .src      (op_in),
        .kind     (shift_kind_e'(shift_kind)),
        .amt_raw  (shift_amt),
        .from_reg (amt_is_reg),
        .cin      (carry_in),
        .res      (sh_res),
        .cout     (sh_cout)
    );

    // Rotated constant: byte rotated right by twice the rotate field
    assign k_src   = {{(DATA_W-CONST_W){1'b0}}, op_in[CONST_W-1:0]};
    assign k_field = op_in[CONST_W+ROTF_W-1:CONST_W];
    assign k_amt   = SHW'({k_field, 1'b0});

    opshift_rotator #(.W(DATA_W)) u_krot (
        .din  (k_src),
        .amt  (k_amt),
        .dout (k_res)
    );

    always_comb begin
        if (imm_sel) begin
            result    = k_res;
            carry_out = (k_field == '0) ? carry_in : k_res[DATA_W-1];
        end else begin
            result    = sh_res;
            carry_out = sh_cout;
        end
    end

endmodule

// File: rtl/opshift_unit_chk.sv
module opshift_unit_chk #(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8
) (
    input logic [DATA_W-1:0]    op_in,
    input logic [1:0]           shift_kind,
    input logic [REG_AMT_W-1:0] shift_amt,
    input logic                 amt_is_reg,
    input logic                 carry_in,
    input logic                 imm_sel,
    input logic [DATA_W-1:0]    result,
    input logic                 carry_out
);

    logic [2*DATA_W-1:0] dbl;
    logic [5:0]          krot;

    always_comb begin
        dbl  = {24'b0, op_in[7:0], 24'b0, op_in[7:0]};
        krot = {1'b0, op_in[11:8], 1'b0};

        // R3: zero distance, logical left passes value and carry
        if (!imm_sel && shift_kind == 2'd0 && (amt_is_reg ? shift_amt == 8'd0 : shift_amt[4:0] == 5'd0))
            p_lsl_zero_pass_r3: assert (result == op_in && carry_out == carry_in)
                else $error("R3 lsl zero");

        // R4: logical right, immediate zero
        if (!imm_sel && shift_kind == 2'd1 && !amt_is_reg && shift_amt[4:0] == 5'd0)
            p_lsr_imm_zero_r4: assert (result == '0 && carry_out == op_in[31])
                else $error("R4 lsr imm zero");

        // R5: rotate through carry
        if (!imm_sel && shift_kind == 2'd3 && !amt_is_reg && shift_amt[4:0] == 5'd0)
            p_rrx_r5: assert (result == {carry_in, op_in[31:1]} && carry_out == op_in[0])
                else $error("R5 rrx");

        // R6: arithmetic right saturates to sign
        if (!imm_sel && shift_kind == 2'd2 && amt_is_reg && shift_amt >= 8'd32)
            p_asr_fill_r6: assert ($countones(result) == (op_in[31] ? 32 : 0) && carry_out == op_in[31])
                else $error("R6 asr fill");

        // R7: logical shifts beyond the width clear the word and carry
        if (!imm_sel && !shift_kind[1] && amt_is_reg && shift_amt > 8'd32)
            p_logic_big_r7: assert (result == '0 && !carry_out)
                else $error("R7 logical big");

        // R10: rotated constant matches a double-width window
        if (imm_sel)
            p_const_rot_r10: assert (result == dbl[krot +: 32])
                else $error("R10 const rotate");
    end

endmodule

bind opshift_unit opshift_unit_chk #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) u_chk (
    .op_in      (op_in),
    .shift_kind (shift_kind),
    .shift_amt  (shift_amt),
    .amt_is_reg (amt_is_reg),
    .carry_in   (carry_in),
    .imm_sel    (imm_sel),
    .result     (result),
    .carry_out  (carry_out)
);

// File: tb/test_opshift_unit.sv
module test_opshift_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_in = '0;
    logic [1:0]  shift_kind = '0;
    logic [7:0]  shift_amt = '0;
    logic        amt_is_reg = 1'b0;
    logic        carry_in = 1'b0;
    logic        imm_sel = 1'b0;
    logic [31:0] result;
    logic        carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    opshift_unit i_opshift_unit (
        .op_in      (op_in),
        .shift_kind (shift_kind),
        .shift_amt  (shift_amt),
        .amt_is_reg (amt_is_reg),
        .carry_in   (carry_in),
        .imm_sel    (imm_sel),
        .result     (result),
        .carry_out  (carry_out)
    );

    // Reference model written from the requirements: {carry, result}
    function automatic logic [32:0] ref_model(logic [31:0] v, logic [1:0] k, logic [7:0] a,
                                              logic isreg, logic cin, logic imm);
        logic [31:0] r;
        logic        c;
        int          n;
        int          m;
        if (imm) begin
            m = 2 * int'(v[11:8]);
            r = {24'b0, v[7:0]};
            if (m != 0) r = (r >> m) | (r << (32 - m));
            c = (m == 0) ? cin : r[31];
            return {c, r};
        end
        n = isreg ? int'(a) : int'(a[4:0]);
        case (k)
            2'd0: begin
                if (n == 0)       begin r = v; c = cin; end
                else if (n < 32)  begin r = v << n; c = v[32-n]; end
                else if (n == 32) begin r = '0; c = v[0]; end
                else              begin r = '0; c = 1'b0; end
            end
            2'd1: begin
                if (n == 0)       begin r = isreg ? v : 32'd0; c = isreg ? cin : v[31]; end
                else if (n < 32)  begin r = v >> n; c = v[n-1]; end
                else if (n == 32) begin r = '0; c = v[31]; end
                else              begin r = '0; c = 1'b0; end
            end
            2'd2: begin
                if (n == 0)       begin r = v; c = cin; end
                else if (n < 32)  begin r = 32'($signed(v) >>> n); c = v[n-1]; end
                else              begin r = {32{v[31]}}; c = v[31]; end
            end
            default: begin
                if (n == 0) begin
                    if (isreg) begin r = v; c = cin; end
                    else       begin r = {cin, v[31:1]}; c = v[0]; end
                end else begin
                    m = n % 32;
                    r = (m == 0) ? v : ((v >> m) | (v << (32 - m)));
                    c = v[(n-1) % 32];
                end
            end
        endcase
        return {c, r};
    endfunction

    task automatic compare(string tag);
        logic [32:0] exp;
        exp = ref_model(op_in, shift_kind, shift_amt, amt_is_reg, carry_in, imm_sel);
        checks++;
        if (result !== exp[31:0]) begin
            fails++;
            $display("FAIL %s result: actual %h expected %h (kind=%0d amt=%0d reg=%0b imm=%0b)",
                     tag, result, exp[31:0], shift_kind, shift_amt, amt_is_reg, imm_sel);
        end
        checks++;
        if (carry_out !== exp[32]) begin
            fails++;
            $display("FAIL %s carry: actual %0b expected %0b (kind=%0d amt=%0d reg=%0b imm=%0b)",
                     tag, carry_out, exp[32], shift_kind, shift_amt, amt_is_reg, imm_sel);
        end
    endtask

    task automatic apply(logic [31:0] v, logic [1:0] k, logic [7:0] a, logic isreg,
                         logic cin, logic imm, string tag);
        @(posedge clk);
        op_in = v; shift_kind = k; shift_amt = a; amt_is_reg = isreg; carry_in = cin; imm_sel = imm;
        @(negedge clk);
        compare(tag);
    endtask

    function automatic string tag_of(logic [1:0] k, logic [7:0] a, logic isreg, logic imm);
        int n;
        n = isreg ? int'(a) : int'(a[4:0]);
        if (imm) return "R10";
        if (n == 0) begin
            if (!isreg && k == 2'd1) return "R4";
            if (!isreg && k == 2'd3) return "R5";
            return "R3";
        end
        if (n < 32) return "R1_R2";
        if (k == 2'd2) return "R6";
        if (k == 2'd3) return "R8";
        return "R7";
    endfunction

    initial begin
        logic [31:0] sv;
        logic [1:0]  sk;
        logic [7:0]  sa;
        logic        sr;
        logic        sc;
        logic        si;
        int          pick;
        logic [32:0] e1;
        logic [32:0] e2;
        void'($urandom(32'h5eed_0b57));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset state: all-zero inputs give zero outputs
        @(negedge clk);
        checks++;
        if (result !== 32'd0 || carry_out !== 1'b0) begin
            fails++;
            $display("FAIL R3 idle: actual %h/%0b expected 0/0", result, carry_out);
        end

        // R1 / R2 directed
        apply(32'h8000_0001, 2'd0, 8'd1,  1'b0, 1'b0, 1'b0, "R1_R2");
        apply(32'h8000_0001, 2'd1, 8'd1,  1'b0, 1'b0, 1'b0, "R1_R2");
        apply(32'h8000_0010, 2'd2, 8'd5,  1'b1, 1'b0, 1'b0, "R1_R2");
        apply(32'h1234_5678, 2'd3, 8'd31, 1'b0, 1'b1, 1'b0, "R1_R2");
        // R3 zero distance pass-through
        apply(32'hdead_beef, 2'd0, 8'd0, 1'b0, 1'b1, 1'b0, "R3");
        apply(32'hdead_beef, 2'd2, 8'd0, 1'b0, 1'b1, 1'b0, "R3");
        apply(32'hdead_beef, 2'd3, 8'd0, 1'b1, 1'b1, 1'b0, "R3");
        apply(32'hdead_beef, 2'd1, 8'd0, 1'b1, 1'b0, 1'b0, "R3");
        // R4, R5
        apply(32'h8000_0000, 2'd1, 8'd0, 1'b0, 1'b0, 1'b0, "R4");
        apply(32'h0000_0003, 2'd3, 8'd0, 1'b0, 1'b0, 1'b0, "R5");
        apply(32'h0000_0002, 2'd3, 8'd0, 1'b0, 1'b1, 1'b0, "R5");
        // R6
        apply(32'h8000_0000, 2'd2, 8'd32,  1'b1, 1'b0, 1'b0, "R6");
        apply(32'h7fff_ffff, 2'd2, 8'd200, 1'b1, 1'b1, 1'b0, "R6");
        // R7
        apply(32'h0000_0001, 2'd0, 8'd32, 1'b1, 1'b0, 1'b0, "R7");
        apply(32'h8000_0000, 2'd1, 8'd32, 1'b1, 1'b0, 1'b0, "R7");
        apply(32'hffff_ffff, 2'd0, 8'd33, 1'b1, 1'b1, 1'b0, "R7");
        apply(32'hffff_ffff, 2'd1, 8'd255, 1'b1, 1'b1, 1'b0, "R7");
        // R8
        apply(32'h8000_0001, 2'd3, 8'd32, 1'b1, 1'b0, 1'b0, "R8");
        apply(32'h1234_5678, 2'd3, 8'd36, 1'b1, 1'b0, 1'b0, "R8");
        apply(32'h1234_5678, 2'd3, 8'd64, 1'b1, 1'b1, 1'b0, "R8");
        // R9: upper immediate bits are ignored
        apply(32'hf0f0_1234, 2'd0, 8'he4, 1'b0, 1'b0, 1'b0, "R9");
        apply(32'hf0f0_1234, 2'd1, 8'h20, 1'b0, 1'b1, 1'b0, "R9");
        // R10 rotated constants; kind and distance ignored
        apply(32'h0000_00ff, 2'd2, 8'd7,  1'b1, 1'b1, 1'b1, "R10");
        apply(32'h0000_01ab, 2'd0, 8'd3,  1'b0, 1'b0, 1'b1, "R10");
        apply(32'h0000_0f80, 2'd3, 8'd40, 1'b1, 1'b0, 1'b1, "R10");
        apply(32'h0000_0c3f, 2'd1, 8'd0,  1'b0, 1'b1, 1'b1, "R10");

        // R11: outputs follow an input change without a clock edge
        @(negedge clk);
        op_in = 32'h0000_0100; shift_kind = 2'd0; shift_amt = 8'd4;
        amt_is_reg = 1'b1; carry_in = 1'b0; imm_sel = 1'b0;
        #1;
        e1 = ref_model(op_in, shift_kind, shift_amt, amt_is_reg, carry_in, imm_sel);
        checks++;
        if (result !== e1[31:0]) begin
            fails++;
            $display("FAIL R11 first: actual %h expected %h", result, e1[31:0]);
        end
        shift_amt = 8'd24;
        #1;
        e2 = ref_model(op_in, shift_kind, shift_amt, amt_is_reg, carry_in, imm_sel);
        checks++;
        if (result !== e2[31:0] || carry_out !== e2[32]) begin
            fails++;
            $display("FAIL R11 second: actual %h/%0b expected %h/%0b",
                     result, carry_out, e2[31:0], e2[32]);
        end

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            sv   = $urandom;
            sk   = 2'($urandom_range(0, 3));
            pick = $urandom_range(0, 9);
            case (pick)
                0:       sa = 8'd0;
                1:       sa = 8'd32;
                2:       sa = 8'd33;
                3:       sa = 8'd31;
                default: sa = 8'($urandom);
            endcase
            sr = 1'($urandom);
            sc = 1'($urandom);
            si = ($urandom_range(0, 7) == 0);
            apply(sv, sk, sa, sr, sc, si, tag_of(sk, sa, sr, si));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule